// File: doc/BRIEF.md
# Dithered Timer Capture/Compare Channel

This block is one channel of a general-purpose timer, built around a 20-bit capture/compare word. Driven as an output, it keeps a bus-written compare value, optionally preloaded until the next update event. It compares that value with an external free-running 16-bit counter and drives a registered PWM-style match output. Driven as an input, it takes a snapshot of the counter on each capture strobe. In that mode the word is read-only from the bus.

A dither-enable bit changes the layout of the word. With dither off, the compare or capture value sits in the low 16 bits and the top four bits of the word are zero. With dither on, the 16-bit integer part sits in bits 19:4 and a 4-bit fraction sits in bits 3:0. The fraction raises the compare value by one count in some periods of a 16-period cycle, so the average duty cycle has sub-count resolution. Captures in dither mode are stored shifted left by four bits, with the fraction bits zero.

The surrounding timer supplies the counter, the update-event strobe, the capture strobe and the three configuration bits. This block only holds the word and produces the match output.

Top module: `tcc_channel`

## Requirements
- R1: After reset, the bus read value is 0 and `cmp_out` is 0.
- R2: In output mode (`dir_in`=0) with `preload_en`=0, a bus write updates both the read value and the active compare value at the same clock edge, so the next comparison already uses the new value.
- R3: In output mode with `preload_en`=1, a write changes the read value at once, but the active compare value is unchanged until an edge where `upd_ev`=1. That edge copies the read value held before the edge into the active compare value.
- R4: A write with `dither_en`=0 stores `bus_wdata[15:0]`, and bits 19:16 read as zero. The integer compare value is the active value's bits 15:0.
- R5: A write with `dither_en`=1 stores `bus_wdata[19:0]`. The integer compare value is bits 19:4 and the fraction is bits 3:0.
- R6: `cmp_out` is registered. One cycle after the inputs are presented, it is 1 when output mode is selected and the counter is below the effective compare value, and 0 otherwise. It is always 0 in input mode.
- R7: A 4-bit period index resets to 0 and increments, wrapping, on every `upd_ev`. With `dither_en`=1, the effective compare value in period p is integer+1 when the bit-reversed p is less than the fraction, and the integer otherwise. Exactly `fraction` periods of every 16 get the extra count.
- R8: In input mode with `dither_en`=0, a `cap_ev` stores the counter in bits 15:0, and bits 19:16 read as zero.
- R9: In input mode with `dither_en`=1, a `cap_ev` stores the counter in bits 19:4, and bits 3:0 read as zero.
- R10: In input mode, bus writes do not change the stored word. When a write and a capture arrive in the same cycle, the capture value is stored.
- R11: Bits 31:20 of the read value are always zero, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe for the capture/compare word |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Capture/compare word read value |
| cnt_i | input | 16 | Free-running timer counter |
| upd_ev | input | 1 | Update event strobe |
| cap_ev | input | 1 | Capture event strobe |
| preload_en | input | 1 | 1 = compare writes wait for an update event |
| dither_en | input | 1 | 1 = 16.4 fixed-point layout with dithering |
| dir_in | input | 1 | 0 = output compare, 1 = input capture |
| cmp_out | output | 1 | Registered compare-match output |

## Verification
The read value is due right after the clock edge that takes a write or a capture, because `bus_rdata` is driven directly from the stored word. `cmp_out` is due one edge after the counter and configuration are presented, and it depends on the active value and period index as they stood before that edge. A write with preload off therefore shows in the match result at the next step. A preloaded write shows only at the step after the update edge. The bench drives each step on the falling edge, advances its reference model at the rising edge from the pre-edge state, and compares both outputs shortly after that rising edge.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int CNT_W   = 16;
    localparam int FRAC_W  = 4;
    localparam int REG_W   = CNT_W + FRAC_W;
    localparam int BUS_W   = 32;
    localparam int EFF_W   = CNT_W + 1;

    typedef logic [REG_W-1:0]  ccr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [FRAC_W-1:0] frac_t;
    typedef logic [EFF_W-1:0]  eff_t;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } dir_e;

    typedef struct packed {
        cnt_t  whole;
        frac_t frac;
    } dith_word_t;

    // Store the written word in the layout selected by the dither bit.
    function automatic ccr_t fold_write(input ccr_t w, input logic dith);
        ccr_t r;
        if (dith) r = w;
        else      r = {{FRAC_W{1'b0}}, w[CNT_W-1:0]};
        return r;
    endfunction

    // Place a captured counter value in the selected layout.
    function automatic ccr_t capture_word(input cnt_t c, input logic dith);
        ccr_t r;
        if (dith) r = {c, {FRAC_W{1'b0}}};
        else      r = {{FRAC_W{1'b0}}, c};
        return r;
    endfunction

    function automatic frac_t bit_reverse(input frac_t p);
        frac_t r;
        for (int i = 0; i < FRAC_W; i++) r[i] = p[FRAC_W-1-i];
        return r;
    endfunction

    // A period gets the extra count when its bit-reversed index is below the fraction.
    function automatic logic phase_bumped(input frac_t phase, input frac_t frac);
        return bit_reverse(phase) < frac;
    endfunction

endpackage

// File: rtl/tcc_ccr_store.sv
module tcc_ccr_store
    import tcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_we,
    input  ccr_t wr_word,
    input  cnt_t cnt,
    input  logic upd_ev,
    input  logic cap_ev,
    input  logic preload_en,
    input  logic dither_en,
    input  dir_e dir,
    output ccr_t shadow,
    output ccr_t active
);

    ccr_t shadow_q, active_q;
    ccr_t folded;

    assign folded = fold_write(wr_word, dither_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else if (dir == DIR_IN) begin
            if (cap_ev) shadow_q <= capture_word(cnt, dither_en);
        end else begin
            if (bus_we) begin
                shadow_q <= folded;
                if (!preload_en) active_q <= folded;
            end
            if (preload_en && upd_ev) active_q <= shadow_q;
        end
    end

    assign shadow = shadow_q;
    assign active = active_q;

    // R10
    in_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_IN && bus_we && !cap_ev) |=> $stable(shadow_q));

    // R3
    preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (preload_en && !upd_ev) |=> $stable(active_q));

    // R2
    direct_load_chk: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_OUT && !preload_en && bus_we) |=> (active_q == shadow_q));

    // R9
    dith_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_IN && cap_ev && dither_en) |=>
            (shadow_q[FRAC_W-1:0] == '0 && shadow_q[REG_W-1:FRAC_W] == $past(cnt)));

    // R8
    plain_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_IN && cap_ev && !dither_en) |=>
            (shadow_q[REG_W-1:CNT_W] == '0 && shadow_q[CNT_W-1:0] == $past(cnt)));

endmodule

// File: rtl/tcc_dither.sv
module tcc_dither
    import tcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd_ev,
    input  logic dither_en,
    input  ccr_t active,
    output eff_t eff
);

    frac_t      phase_q;
    dith_word_t dw;
    logic       bump;

    assign dw = dith_word_t'(active);

    always_ff @(posedge clk) begin
        if (rst)         phase_q <= '0;
        else if (upd_ev) phase_q <= phase_q + 1'b1;
    end

    assign bump = phase_bumped(phase_q, dw.frac);

    always_comb begin
        if (dither_en) eff = {1'b0, dw.whole} + EFF_W'(bump);
        else           eff = {1'b0, active[CNT_W-1:0]};
    end

    // R7
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        upd_ev |=> (phase_q == FRAC_W'($past(phase_q) + 1'b1)));

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_ev |=> $stable(phase_q));

endmodule

// File: rtl/tcc_compare.sv
module tcc_compare
    import tcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dir_e dir,
    input  cnt_t cnt,
    input  eff_t eff,
    output logic cmp_out
);

    logic cmp_q;

    always_ff @(posedge clk) begin
        if (rst) cmp_q <= 1'b0;
        else     cmp_q <= (dir == DIR_OUT) && ({1'b0, cnt} < eff);
    end

    assign cmp_out = cmp_q;

    // R6
    in_mode_low_chk: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_IN) |=> !cmp_q);

    // R6
    zero_cmp_low_chk: assert property (@(posedge clk) disable iff (rst)
        (eff == '0) |=> !cmp_q);

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                upd_ev,
    input  logic                cap_ev,
    input  logic                preload_en,
    input  logic                dither_en,
    input  logic                dir_in,
    output logic                cmp_out
);

    ccr_t shadow, active;
    eff_t eff;
    dir_e dir;
    logic unused_hi;

    assign dir       = dir_e'(dir_in);
    assign unused_hi = ^bus_wdata[BUS_W-1:REG_W];

    tcc_ccr_store u_store (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .wr_word    (bus_wdata[REG_W-1:0]),
        .cnt        (cnt_i),
        .upd_ev     (upd_ev),
        .cap_ev     (cap_ev),
        .preload_en (preload_en),
        .dither_en  (dither_en),
        .dir        (dir),
        .shadow     (shadow),
        .active     (active)
    );

    tcc_dither u_dither (
        .clk       (clk),
        .rst       (rst),
        .upd_ev    (upd_ev),
        .dither_en (dither_en),
        .active    (active),
        .eff       (eff)
    );

    tcc_compare u_cmp (
        .clk     (clk),
        .rst     (rst),
        .dir     (dir),
        .cnt     (cnt_i),
        .eff     (eff),
        .cmp_out (cmp_out)
    );

    assign bus_rdata = {{(BUS_W-REG_W){1'b0}}, shadow};

    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> (bus_rdata[BUS_W-1:REG_W] == '0));

endmodule

// File: tb/tcc_channel_bench.sv
module tcc_channel_bench;

    localparam int PERIOD = 10;
    localparam int N_RAND = 4000;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] cnt_i;
    logic        upd_ev, cap_ev, preload_en, dither_en, dir_in;
    logic        cmp_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // reference model state
    logic [19:0] m_shadow, m_active;
    logic [3:0]  m_phase;
    logic        m_cmp;

    always #(PERIOD/2) clk = ~clk;

    tcc_channel u_tcc_channel (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt_i(cnt_i), .upd_ev(upd_ev), .cap_ev(cap_ev),
        .preload_en(preload_en), .dither_en(dither_en), .dir_in(dir_in),
        .cmp_out(cmp_out)
    );

    function automatic logic [3:0] rev4(input logic [3:0] p);
        return {p[0], p[1], p[2], p[3]};
    endfunction

    function automatic logic [16:0] model_eff(input logic [19:0] a,
                                              input logic [3:0] ph,
                                              input logic dith);
        if (dith) return {1'b0, a[19:4]} + ((rev4(ph) < a[3:0]) ? 17'd1 : 17'd0);
        return {1'b0, a[15:0]};
    endfunction

    function automatic logic [19:0] model_store(input logic [31:0] w, input logic dith);
        return dith ? w[19:0] : {4'h0, w[15:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock step: drive on the falling edge, advance model at the rising edge,
    // then compare both outputs.
    task automatic step(input string req, input logic we, input logic [31:0] wd,
                        input logic [15:0] c, input logic up, input logic cp,
                        input logic pre, input logic dith, input logic din);
        logic [19:0] nshadow, nactive;
        @(negedge clk);
        bus_we = we; bus_wdata = wd; cnt_i = c; upd_ev = up; cap_ev = cp;
        preload_en = pre; dither_en = dith; dir_in = din;
        @(posedge clk);
        m_cmp   = !din && ({1'b0, c} < model_eff(m_active, m_phase, dith));
        nshadow = m_shadow;
        nactive = m_active;
        if (din) begin
            if (cp) nshadow = dith ? {c, 4'h0} : {4'h0, c};
        end else begin
            if (we) begin
                nshadow = model_store(wd, dith);
                if (!pre) nactive = model_store(wd, dith);
            end
            if (pre && up) nactive = m_shadow;
        end
        m_shadow = nshadow;
        m_active = nactive;
        if (up) m_phase = m_phase + 4'd1;
        #1;
        check({req, " rdata"}, bus_rdata, {12'h000, m_shadow});
        check({req, " cmp"}, {31'h0, cmp_out}, {31'h0, m_cmp});
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        int highs;
        unused_seed = $urandom(32'h00C0FFEE);
        rst = 1'b1; bus_we = 0; bus_wdata = '0; cnt_i = '0; upd_ev = 0; cap_ev = 0;
        preload_en = 0; dither_en = 0; dir_in = 0;
        m_shadow = '0; m_active = '0; m_phase = '0; m_cmp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset rdata", bus_rdata, 32'h0);
        check("R1 reset cmp", {31'h0, cmp_out}, 32'h0);

        // R2, R4, R11: direct write, high bits dropped
        step("R2", 1, 32'hABCF_1234, 16'h0000, 0, 0, 0, 0, 0);
        check("R4 high bits zero", bus_rdata, 32'h0000_1234);
        step("R2", 0, 0, 16'h1233, 0, 0, 0, 0, 0);
        check("R6 below compare", {31'h0, cmp_out}, 32'h1);
        step("R6", 0, 0, 16'h1234, 0, 0, 0, 0, 0);
        check("R6 equal compare", {31'h0, cmp_out}, 32'h0);

        // R3: preloaded write waits for update
        step("R3", 1, 32'h0000_0100, 16'h0200, 0, 0, 1, 0, 0);
        check("R3 readback new", bus_rdata, 32'h0000_0100);
        step("R3", 0, 0, 16'h0200, 0, 0, 1, 0, 0);
        check("R3 old compare used", {31'h0, cmp_out}, 32'h1);
        step("R3", 0, 0, 16'h0200, 1, 0, 1, 0, 0);
        step("R3", 0, 0, 16'h0200, 0, 0, 1, 0, 0);
        check("R3 new compare after update", {31'h0, cmp_out}, 32'h0);

        // R5, R7: dither integer 100, fraction 5 over a full cycle
        step("R5", 1, 32'hFFF0_0645, 16'h0000, 0, 0, 0, 1, 0);
        check("R5 full word stored", bus_rdata, 32'h0000_0645);
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            step("R7", 0, 0, 16'd100, 1, 0, 0, 1, 0);
            highs += cmp_out;
        end
        check("R7 extra periods", highs, 5);

        // R8, R9, R10: capture layouts, ignored write, capture priority
        step("R8", 0, 0, 16'hBEEF, 0, 1, 0, 0, 1);
        check("R8 plain capture", bus_rdata, 32'h0000_BEEF);
        step("R9", 0, 0, 16'hCAFE, 0, 1, 0, 1, 1);
        check("R9 dither capture", bus_rdata, 32'h000C_AFE0);
        step("R10", 1, 32'h0001_1111, 16'h0000, 0, 0, 0, 0, 1);
        check("R10 write ignored", bus_rdata, 32'h000C_AFE0);
        step("R10", 1, 32'h0001_1111, 16'h4321, 0, 1, 0, 0, 1);
        check("R10 capture wins", bus_rdata, 32'h0000_4321);
        check("R6 input mode low", {31'h0, cmp_out}, 32'h0);

        // random mix
        for (int n = 0; n < N_RAND; n++) begin
            logic [15:0] c;
            c = ($urandom % 2) ? m_active[15:0] + 16'($urandom % 5) - 16'd2
                               : 16'($urandom);
            step("R6 random", ($urandom % 3) == 0, $urandom, c,
                 ($urandom % 6) == 0, ($urandom % 4) == 0, $urandom % 2,
                 $urandom % 2, ($urandom % 4) == 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule